// File: doc/BRIEF.md
# Rotating Register Renamer

This block supplies the rotating-register base used by software-pipelined loops. It keeps one rotation base for each of three register classes: general, predicate and floating-point. A single rotate pulse, issued when a loop branch is taken, moves all of the bases one step together. Because each base steps once per loop branch, a value written to register X in one iteration is read as register X+1 in the next iteration. The register storage is not part of this block.

A translate port takes a register class and a logical register number. It returns the physical index within that class. The general-register rotating region always begins at r32, and its size is set in groups of eight. A size of zero turns off general-register rotation. The predicate and floating-point regions have fixed sizes.

Translation requests and responses use a valid/ready handshake. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. The response appears one cycle later in a single output register. That register holds its value while `resp_ready` is low. While it holds an unconsumed response, `req_ready` is low, so a stalled consumer stalls the requester.

Top module: `rot_rename`

## Requirements
- R1: After reset, `resp_valid` is 0, `req_ready` is 1, all rotation bases are zero and the general region size is zero, so every class translates each number to itself.
- R2: For class 2 (floating-point), numbers 32 to 127 map to 32 + ((n - 32) + base) mod 96, and numbers 0 to 31 map to themselves.
- R3: Each rotate pulse lowers every active base by one, wrapping from 0 to size-1. After a pulse, logical X+1 maps to the physical index that X mapped to before, and the first register of a region maps to the index the last register of that region had.
- R4: For class 1 (predicate), numbers 16 to 63 map to 16 + ((n - 16) + base) mod 48, and numbers 0 to 15 map to themselves.
- R5: A write with `cfg_we` sets the general region size to 8 × `cfg_gr_groups`, limited to 96. For class 0 (general), numbers 32 to 32+size-1 map to 32 + ((n - 32) + base) mod size. All other general numbers map to themselves.
- R6: When the general region size is zero, general numbers map to themselves and rotate pulses leave the general base unchanged. Predicate and floating-point rotation are not affected.
- R7: `clr` or `cfg_we` resets all three bases to zero at the next edge. This takes priority over a rotate pulse in the same cycle.
- R8: `req_ready` equals `!resp_valid || resp_ready`. While `resp_valid` is 1 and `resp_ready` is 0, `resp_phys` and `resp_valid` hold their values.
- R9: A request is translated with the bases in effect before any rotate pulse that arrives in the same cycle.
- R10: For class 3 (`req_cls` = 3), the number is returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Reset all rotation bases |
| rotate | input | 1 | Loop-branch rotate pulse |
| cfg_we | input | 1 | Load the general region size |
| cfg_gr_groups | input | 4 | General region size in groups of eight |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request can be accepted |
| req_cls | input | 2 | Class: 0 general, 1 predicate, 2 floating-point, 3 pass-through |
| req_num | input | 7 | Logical register number |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Consumer takes the response |
| resp_phys | output | 7 | Physical register index |

## Verification
The bench builds the block with its default parameters: a 7-bit register number, a general region of up to 96 registers starting at r32, a 48-entry predicate region starting at p16, and a 96-entry floating-point region starting at f32. With these values the bench can reach the wrap from base 0 to size-1 in every class, the limit applied to an oversized group count, and the upper edge of a 16-entry general region, where r48 stays outside the region. Rotating sixteen times in a row brings the general base back to a value it already had, while the larger regions move to new bases. This separates the modulus of each class.

// File: rtl/rot_pkg.sv
package rot_pkg;
  typedef enum logic [1:0] {
    CLS_GR   = 2'd0,
    CLS_PR   = 2'd1,
    CLS_FR   = 2'd2,
    CLS_PASS = 2'd3
  } reg_cls_e;

  localparam int NUM_ROT_CLS = 3;
endpackage

// File: rtl/rot_base_ctr.sv
module rot_base_ctr #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] size,
  output logic [W-1:0] base
);
  logic size_zero;
  assign size_zero = (size == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0;
    end else if (clr || size_zero) begin
      base <= '0;
    end else if (step) begin
      if (base == '0) base <= size - W'(1);
      else            base <= base - W'(1);
    end
  end
endmodule

// File: rtl/rot_map.sv
module rot_map #(
  parameter int W = 7
) (
  input  logic [W-1:0] logical,
  input  logic [W-1:0] first,
  input  logic [W-1:0] size,
  input  logic [W-1:0] base,
  output logic [W-1:0] phys
);
  logic [W:0] rel;
  logic [W:0] off;
  logic [W:0] wrapped;
  logic       in_region;

  always_comb begin
    rel       = {1'b0, logical} - {1'b0, first};
    in_region = (size != '0) && (logical >= first) && (rel < {1'b0, size});
    off       = rel + {1'b0, base};
    if (off >= {1'b0, size}) wrapped = off - {1'b0, size};
    else                     wrapped = off;
    if (in_region) phys = first + wrapped[W-1:0];
    else           phys = logical;
  end
endmodule

// File: rtl/rot_rename.sv
module rot_rename
  import rot_pkg::*;
#(
  parameter int W        = 7,
  parameter int GR_FIRST = 32,
  parameter int GR_MAX   = 96,
  parameter int PR_FIRST = 16,
  parameter int PR_SIZE  = 48,
  parameter int FR_FIRST = 32,
  parameter int FR_SIZE  = 96,
  localparam int GRP_MAX = GR_MAX / 8,
  localparam int GW      = $clog2(GRP_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          rotate,
  input  logic          cfg_we,
  input  logic [GW-1:0] cfg_gr_groups,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_cls,
  input  logic [W-1:0]  req_num,
  output logic          resp_valid,
  input  logic          resp_ready,
  output logic [W-1:0]  resp_phys
);
  logic [W-1:0] gr_size;
  logic [W-1:0] grp_ext;
  logic         base_clr;

  logic [W-1:0] cls_first [NUM_ROT_CLS];
  logic [W-1:0] cls_size  [NUM_ROT_CLS];
  logic [W-1:0] cls_base  [NUM_ROT_CLS];
  logic [W-1:0] cls_phys  [NUM_ROT_CLS];

  assign grp_ext  = W'(cfg_gr_groups);
  assign base_clr = clr | cfg_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gr_size <= '0;
    end else if (cfg_we) begin
      if (grp_ext > W'(GRP_MAX)) gr_size <= W'(GR_MAX);
      else                       gr_size <= grp_ext << 3;
    end
  end

  assign cls_first[CLS_GR] = W'(GR_FIRST);
  assign cls_first[CLS_PR] = W'(PR_FIRST);
  assign cls_first[CLS_FR] = W'(FR_FIRST);
  assign cls_size[CLS_GR]  = gr_size;
  assign cls_size[CLS_PR]  = W'(PR_SIZE);
  assign cls_size[CLS_FR]  = W'(FR_SIZE);

  for (genvar c = 0; c < NUM_ROT_CLS; c++) begin : g_cls
    rot_base_ctr #(.W(W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (base_clr),
      .step  (rotate),
      .size  (cls_size[c]),
      .base  (cls_base[c])
    );

    rot_map #(.W(W)) u_map (
      .logical (req_num),
      .first   (cls_first[c]),
      .size    (cls_size[c]),
      .base    (cls_base[c]),
      .phys    (cls_phys[c])
    );
  end

  logic [W-1:0] sel_phys;
  reg_cls_e     cls_q;

  always_comb begin
    cls_q = reg_cls_e'(req_cls);
    case (cls_q)
      CLS_GR:  sel_phys = cls_phys[CLS_GR];
      CLS_PR:  sel_phys = cls_phys[CLS_PR];
      CLS_FR:  sel_phys = cls_phys[CLS_FR];
      default: sel_phys = req_num;
    endcase
  end

  assign req_ready = !resp_valid || resp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_phys  <= '0;
    end else if (req_ready) begin
      resp_valid <= req_valid;
      if (req_valid) resp_phys <= sel_phys;
    end
  end
endmodule

// File: rtl/rot_rename_chk.sv
module rot_rename_chk #(
  parameter int W       = 7,
  parameter int GR_MAX  = 96,
  parameter int PR_SIZE = 48,
  parameter int FR_SIZE = 96
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr,
  input logic         rotate,
  input logic         cfg_we,
  input logic         req_valid,
  input logic         req_ready,
  input logic         resp_valid,
  input logic         resp_ready,
  input logic [W-1:0] resp_phys,
  input logic [W-1:0] gr_size,
  input logic [W-1:0] base_gr,
  input logic [W-1:0] base_pr,
  input logic [W-1:0] base_fr
);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_phys));

  a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> resp_valid);

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr || cfg_we |=> base_gr == '0 && base_pr == '0 && base_fr == '0);

  a_r5_grain: assert property (@(posedge clk) disable iff (!rst_n)
    gr_size[2:0] == 3'd0 && gr_size <= W'(GR_MAX));

  a_r6_gr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    gr_size == '0 |-> base_gr == '0);

  a_r4_pr_range: assert property (@(posedge clk) disable iff (!rst_n)
    base_pr < W'(PR_SIZE));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    rotate && !clr && !cfg_we |=> !$stable(base_fr) && base_fr < W'(FR_SIZE));
endmodule

bind rot_rename rot_rename_chk #(
  .W(W), .GR_MAX(GR_MAX), .PR_SIZE(PR_SIZE), .FR_SIZE(FR_SIZE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr        (clr),
  .rotate     (rotate),
  .cfg_we     (cfg_we),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .resp_ready (resp_ready),
  .resp_phys  (resp_phys),
  .gr_size    (gr_size),
  .base_gr    (cls_base[0]),
  .base_pr    (cls_base[1]),
  .base_fr    (cls_base[2])
);

// File: tb/rot_rename_bench.sv
`timescale 1ns/1ps
module rot_rename_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       rotate = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_gr_groups = '0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_cls = '0;
  logic [6:0] req_num = '0;
  logic       resp_valid;
  logic       resp_ready = 1'b1;
  logic [6:0] resp_phys;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rot_rename u_rot_rename (
    .clk(clk), .rst_n(rst_n), .clr(clr), .rotate(rotate), .cfg_we(cfg_we),
    .cfg_gr_groups(cfg_gr_groups), .req_valid(req_valid), .req_ready(req_ready),
    .req_cls(req_cls), .req_num(req_num), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_phys(resp_phys)
  );

  // {rotations before, class, logical, expected physical}; general size 16
  localparam logic [20:0] VEC [18] = '{
    {5'd0,  2'd0, 7'd32,  7'd32},   // R5
    {5'd0,  2'd0, 7'd47,  7'd47},   // R5
    {5'd1,  2'd0, 7'd32,  7'd47},   // R3 top wraps to bottom
    {5'd0,  2'd0, 7'd33,  7'd32},   // R3 X -> X+1
    {5'd0,  2'd0, 7'd48,  7'd48},   // R5 above region
    {5'd0,  2'd0, 7'd5,   7'd5},    // R5 static
    {5'd0,  2'd1, 7'd16,  7'd63},   // R4
    {5'd0,  2'd1, 7'd17,  7'd16},   // R4
    {5'd0,  2'd1, 7'd15,  7'd15},   // R4 static
    {5'd0,  2'd2, 7'd32,  7'd127},  // R2
    {5'd0,  2'd2, 7'd127, 7'd126},  // R2
    {5'd0,  2'd2, 7'd31,  7'd31},   // R2 static
    {5'd3,  2'd0, 7'd40,  7'd36},   // R5
    {5'd0,  2'd1, 7'd63,  7'd59},   // R4
    {5'd0,  2'd2, 7'd100, 7'd96},   // R2
    {5'd0,  2'd3, 7'd77,  7'd77},   // R10
    {5'd16, 2'd1, 7'd20,  7'd48},   // R4
    {5'd0,  2'd2, 7'd32,  7'd108}   // R2
  };

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_rotate(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) rotate = 1'b1;
      @(negedge clk) rotate = 1'b0;
    end
  endtask

  task automatic xlate(input logic [1:0] c, input logic [6:0] num, output logic [6:0] ph);
    @(negedge clk);
    req_valid = 1'b1; req_cls = c; req_num = num;
    @(negedge clk);
    req_valid = 1'b0;
    ph = resp_valid ? resp_phys : 7'bx;
  endtask

  task automatic set_groups(input logic [3:0] g);
    @(negedge clk) begin cfg_we = 1'b1; cfg_gr_groups = g; end
    @(negedge clk) cfg_we = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [6:0] ph;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 resp_valid", {6'd0, resp_valid}, 7'd0);
    check("R1 req_ready", {6'd0, req_ready}, 7'd1);
    xlate(2'd0, 7'd40, ph); check("R1 gr identity", ph, 7'd40);
    xlate(2'd2, 7'd32, ph); check("R1 fr identity", ph, 7'd32);

    do_rotate(1);
    xlate(2'd0, 7'd40, ph); check("R6 gr unrotated", ph, 7'd40);
    xlate(2'd2, 7'd32, ph); check("R6 fr rotates", ph, 7'd127);
    xlate(2'd1, 7'd16, ph); check("R6 pr rotates", ph, 7'd63);

    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    xlate(2'd2, 7'd32, ph); check("R7 clr", ph, 7'd32);

    set_groups(4'd2);
    for (int v = 0; v < 18; v++) begin
      do_rotate(int'(VEC[v][20:16]));
      xlate(VEC[v][15:14], VEC[v][13:7], ph);
      check($sformatf("R2-5,R10 vector %0d", v), ph, VEC[v][6:0]);
    end

    // R7: clear wins over rotate in the same cycle
    @(negedge clk) begin clr = 1'b1; rotate = 1'b1; end
    @(negedge clk) begin clr = 1'b0; rotate = 1'b0; end
    xlate(2'd2, 7'd32, ph); check("R7 clr priority", ph, 7'd32);

    // R9: accept and rotate together
    @(negedge clk) begin rotate = 1'b1; req_valid = 1'b1; req_cls = 2'd2; req_num = 7'd32; end
    @(negedge clk) begin rotate = 1'b0; req_valid = 1'b0; end
    check("R9 old base", resp_phys, 7'd32);
    xlate(2'd2, 7'd32, ph); check("R9 new base", ph, 7'd127);

    // R5: group count above limit; cfg also clears
    set_groups(4'd15);
    xlate(2'd2, 7'd32, ph); check("R7 cfg clears", ph, 7'd32);
    do_rotate(1);
    xlate(2'd0, 7'd32, ph); check("R5 clamp 96", ph, 7'd127);
    xlate(2'd0, 7'd127, ph); check("R5 clamp top", ph, 7'd126);

    set_groups(4'd1);
    do_rotate(1);
    xlate(2'd0, 7'd39, ph); check("R5 size 8", ph, 7'd38);
    xlate(2'd0, 7'd40, ph); check("R5 size 8 edge", ph, 7'd40);

    // R8: back-pressure
    @(negedge clk) begin resp_ready = 1'b0; req_valid = 1'b1; req_cls = 2'd1; req_num = 7'd20; end
    @(negedge clk) req_valid = 1'b0;
    check("R8 valid held", {6'd0, resp_valid}, 7'd1);
    check("R8 ready low", {6'd0, req_ready}, 7'd0);
    ph = resp_phys;
    do_rotate(1);
    check("R8 phys stable", resp_phys, ph);
    check("R8 still valid", {6'd0, resp_valid}, 7'd1);
    @(negedge clk) resp_ready = 1'b1;
    @(negedge clk);
    check("R8 drained", {6'd0, resp_valid}, 7'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule